// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Status Unit

This unit collects three event sources of a real-time clock (a periodic divider tick, an alarm match and the end of a time-update cycle) and holds each one in a sticky flag. It gates each flag with its enable bit and combines the results into a registered master request. That request drives an active-low interrupt line that suits a wired-OR, open-drain style connection. Software reads the flags through a status byte, and a read of that byte clears all flags on the following clock edge.

A second read-only byte reports whether the backup supply is still good. That bit is sampled from an input every cycle, and reset never touches it, so it keeps its meaning across resets. The divider, the alarm comparator, the time counters and the bus timing sit outside this unit. It only sees one-cycle event strobes, the enables, and a read strobe with a byte select.

Top module: `rtc_irq_status`

## Requirements
- R1: With `rd_sel_i` = 0 the read byte is {master, periodic, alarm, update, 0000}: the master flag is at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update flag at bit 4. Bits 3..0 are always 0.
- R2: On every clock edge outside reset, the master flag is loaded with (periodic AND its enable) OR (alarm AND its enable) OR (update AND its enable). The flag values used are the ones being loaded on that same edge.
- R3: `irq_n_o` is 0 exactly when the master flag is 1.
- R4: An event strobe sets its flag on the next clock edge whatever the state of its enable. Event bits are periodic = bit 0, alarm = bit 1, update = bit 2.
- R5: A read strobe with `rd_sel_i` = 0 returns the flags as they stand in that cycle. All flags clear on the next edge.
- R6: An event strobe in the same cycle as a clearing read wins: its flag is set after the edge.
- R7: Dropping an enable while its flag is set deasserts the master flag and raises `irq_n_o` on the next edge. The flag itself stays set.
- R8: While `rst_n` is 0 all flags and the master flag are 0 and `irq_n_o` is 1. After `rst_n` rises, flags stay clear for two more clock edges.
- R9: With `rd_sel_i` = 1 the read byte is {valid, 0000000}, where valid is `bat_good_i` sampled on the previous clock edge.
- R10: The validity bit keeps following `bat_good_i` during and after reset; reset does not clear it.
- R11: A read strobe with `rd_sel_i` = 1 leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| evt_i | input | 3 | One-cycle event strobes: bit 0 periodic, bit 1 alarm, bit 2 update ended |
| en_i | input | 3 | Interrupt enables, same bit order as `evt_i` |
| rd_stb_i | input | 1 | Read strobe for the selected byte |
| rd_sel_i | input | 1 | Byte select: 0 status flags, 1 validity |
| bat_good_i | input | 1 | Backup supply good indication |
| rd_data_o | output | 8 | Read data of the selected byte |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench fires an event in the same cycle as a clearing read. A design that let the clear win would lose that event and read 0 in the flag. It drops an enable while the flag is set and expects the interrupt line to rise one edge later with the flag still visible. A design that cleared the flag, or used a stale enable, shows up in the status byte or in `irq_n_o`. It also pulses reset with the backup-good input high and then low. This exposes a validity bit that resets to 0 or stops tracking while reset is held. Validity-byte reads are mixed in as well, to catch a clear that ignores the byte select.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_SRC     = 3;
  localparam int DATA_W      = 8;
  localparam int SYNC_STAGES = 2;
  localparam int SRC_PER     = 0;
  localparam int SRC_ALM     = 1;
  localparam int SRC_UPD     = 2;
  localparam int MASTER_BIT  = DATA_W - 1;
  // flag of source i sits at bit MASTER_BIT-1-i
  localparam int PAD_W       = DATA_W - 1 - NUM_SRC;
  localparam int VLD_PAD_W   = DATA_W - 1;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_VALID = 1'b1} byte_sel_e;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] flag_nxt_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic upd_en;
    logic nxt;

    always_comb begin
      // event beats a simultaneous clear
      nxt    = evt_i[i] | (flag_q[i] & ~clr_i);
      upd_en = evt_i[i] | clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[i] <= 1'b0;
      else if (upd_en) flag_q[i] <= nxt;
    end

    assign flag_nxt_o[i] = upd_en ? nxt : flag_q[i];
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_irq_combine.sv
module rtc_irq_combine #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_nxt_i,
  input  logic [N-1:0] en_i,
  output logic         irqf_o,
  output logic         irq_n_o
);
  logic irqf_q;
  logic irqf_d;

  always_comb begin
    irqf_d = |(flag_nxt_i & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqf_q <= 1'b0;
    else        irqf_q <= irqf_d;
  end

  assign irqf_o  = irqf_q;
  assign irq_n_o = ~irqf_q;
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic              rd_stb_i,
  input  logic              rd_sel_i,
  input  logic              bat_good_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_n_o
);
  logic               rst_n_s;
  logic               clr;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_nxt;
  logic               irqf_q;
  logic               vld_q;
  logic [NUM_SRC-1:0] flag_rev;

  rtc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  always_comb begin
    clr = rd_stb_i & (byte_sel_e'(rd_sel_i) == SEL_STATUS);
  end

  rtc_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .evt_i      (evt_i),
    .clr_i      (clr),
    .flag_o     (flag_q),
    .flag_nxt_o (flag_nxt)
  );

  rtc_irq_combine #(.N(NUM_SRC)) u_combine (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .flag_nxt_i (flag_nxt),
    .en_i       (en_i),
    .irqf_o     (irqf_q),
    .irq_n_o    (irq_n_o)
  );

  // validity sample: no reset by intent
  always_ff @(posedge clk) begin
    vld_q <= bat_good_i;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rev
    assign flag_rev[NUM_SRC-1-i] = flag_q[i];
  end

  always_comb begin
    if (byte_sel_e'(rd_sel_i) == SEL_VALID)
      rd_data_o = {vld_q, {VLD_PAD_W{1'b0}}};
    else
      rd_data_o = {irqf_q, flag_rev, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/rtc_irq_status_chk.sv
module rtc_irq_status_chk
  import rtc_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rst_n_s,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic               rd_stb_i,
  input logic               rd_sel_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               irq_n_o,
  input logic [NUM_SRC-1:0] flag_q,
  input logic               irqf_q
);
  p_low_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel_i |-> rd_data_o[PAD_W-1:0] == '0);

  p_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n_s |=> irqf_q == |(flag_q & $past(en_i)));

  p_irq_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel_i |-> rd_data_o[MASTER_BIT] == !irq_n_o);

  p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n_s && evt_i != '0) |=> (flag_q & $past(evt_i)) == $past(evt_i));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n_s && rd_stb_i && !rd_sel_i) |=> flag_q == $past(evt_i));

  p_valid_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel_i |-> rd_data_o[VLD_PAD_W-1:0] == '0);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n_s && evt_i == '0 && !(rd_stb_i && !rd_sel_i)) |=> $stable(flag_q));
endmodule

bind rtc_irq_status rtc_irq_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_n_s   (rst_n_s),
  .evt_i     (evt_i),
  .en_i      (en_i),
  .rd_stb_i  (rd_stb_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .irq_n_o   (irq_n_o),
  .flag_q    (flag_q),
  .irqf_q    (irqf_q)
);

// File: tb/rtc_irq_status_tb.sv
module rtc_irq_status_tb;
  logic       clk;
  logic       rst_n;
  logic [2:0] evt;
  logic [2:0] en;
  logic       rd_stb;
  logic       rd_sel;
  logic       bat;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_chk;
  int n_bad;

  // model state
  logic [2:0] m_fl;
  logic       m_irq;
  logic       m_vld;
  logic [1:0] m_sync;

  rtc_irq_status u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .en_i       (en),
    .rd_stb_i   (rd_stb),
    .rd_sel_i   (rd_sel),
    .bat_good_i (bat),
    .rd_data_o  (rd_data),
    .irq_n_o    (irq_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] exp_status(logic irq, logic [2:0] fl);
    return {irq, fl[0], fl[1], fl[2], 4'b0000};
  endfunction

  function automatic logic [7:0] exp_byte(logic sel);
    return sel ? {m_vld, 7'b0} : exp_status(m_irq, m_fl);
  endfunction

  task automatic model_edge();
    logic [2:0] nf;
    if (!rst_n) begin
      m_fl = '0; m_irq = 1'b0; m_sync = '0;
    end else begin
      if (!m_sync[1]) begin
        m_fl = '0; m_irq = 1'b0;
      end else begin
        nf = (rd_stb && !rd_sel) ? evt : (m_fl | evt);
        m_irq = |(nf & en);
        m_fl = nf;
      end
      m_sync = {m_sync[0], 1'b1};
    end
    m_vld = bat;
  endtask

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #2;
  endtask

  task automatic drive(logic [2:0] e, logic [2:0] n, logic s, logic sel, logic b);
    evt = e; en = n; rd_stb = s; rd_sel = sel; bat = b;
    #1;
  endtask

  task automatic check_all(string tag);
    chk8(tag, rd_data, exp_byte(rd_sel));
    chk8({tag, " irq_n (R3)"}, {7'b0, irq_n}, {7'b0, ~m_irq});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    n_chk = 0; n_bad = 0;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    m_fl = '0; m_irq = 1'b0; m_sync = '0; m_vld = 1'b1;
    drive(3'b000, 3'b000, 1'b0, 1'b0, 1'b1);
    repeat (3) cyc();
    // R8 reset state, with events applied while held
    drive(3'b111, 3'b111, 1'b0, 1'b0, 1'b1);
    cyc();
    check_all("R8 reset state");
    drive(3'b000, 3'b111, 1'b0, 1'b1, 1'b1);
    #1;
    check_all("R10 valid in reset");
    rst_n = 1'b1;
    drive(3'b111, 3'b111, 1'b0, 1'b0, 1'b1);
    cyc();
    check_all("R8 sync hold 1");
    cyc();
    check_all("R8 sync hold 2");
    drive(3'b000, 3'b000, 1'b0, 1'b0, 1'b1);
    cyc();
    check_all("R8 after release");

    // R4: event with enable off still sets flag, no irq
    drive(3'b010, 3'b000, 1'b0, 1'b0, 1'b1);
    cyc();
    drive(3'b000, 3'b000, 1'b0, 1'b0, 1'b1);
    chk8("R4 alarm flag, enable off", rd_data, 8'b0010_0000);
    check_all("R4 alarm");
    // R2: enabling it raises master next edge
    drive(3'b000, 3'b010, 1'b0, 1'b0, 1'b1);
    cyc();
    chk8("R2 master with alarm enabled", rd_data, 8'b1010_0000);
    check_all("R2");
    // R11: validity byte read does not clear
    drive(3'b000, 3'b010, 1'b1, 1'b1, 1'b1);
    cyc();
    drive(3'b000, 3'b010, 1'b0, 1'b0, 1'b1);
    chk8("R11 flags after valid read", rd_data, 8'b1010_0000);
    // R7: drop enable, flag stays, irq goes away
    drive(3'b000, 3'b000, 1'b0, 1'b0, 1'b1);
    cyc();
    chk8("R7 flag kept, master off", rd_data, 8'b0010_0000);
    check_all("R7");
    // R5: read returns pre-clear value, then clears; R6 periodic event wins
    drive(3'b001, 3'b001, 1'b1, 1'b0, 1'b1);
    chk8("R5 read data before clear", rd_data, 8'b0010_0000);
    cyc();
    drive(3'b000, 3'b001, 1'b0, 1'b0, 1'b1);
    chk8("R6 event wins over clear", rd_data, 8'b1100_0000);
    check_all("R5 R6");
    drive(3'b000, 3'b001, 1'b1, 1'b0, 1'b1);
    cyc();
    drive(3'b000, 3'b001, 1'b0, 1'b0, 1'b1);
    chk8("R5 cleared", rd_data, 8'b0000_0000);
    // R9: validity follows bat_good
    drive(3'b000, 3'b000, 1'b0, 1'b1, 1'b0);
    cyc();
    chk8("R9 valid low", rd_data, 8'b0000_0000);
    drive(3'b100, 3'b100, 1'b0, 1'b1, 1'b1);
    cyc();
    chk8("R9 valid high", rd_data, 8'b1000_0000);
    drive(3'b000, 3'b100, 1'b0, 1'b0, 1'b1);
    chk8("R1 update flag bit 4", rd_data, 8'b1001_0000);

    // R10: reset pulse with bat low, validity still tracks
    rst_n = 1'b0;
    m_fl = '0; m_irq = 1'b0; m_sync = '0;
    drive(3'b000, 3'b000, 1'b0, 1'b1, 1'b0);
    cyc();
    check_all("R10 valid low in reset");
    drive(3'b000, 3'b000, 1'b0, 1'b1, 1'b1);
    cyc();
    check_all("R10 valid high in reset");
    rst_n = 1'b1;
    cyc(); cyc();
    check_all("R10 after reset");

    // random phase: R1 R2 R3 R4 R5 R11
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] e;
      e = '0;
      for (int k = 0; k < 3; k++) e[k] = ($urandom_range(0, 5) == 0);
      drive(e, 3'($urandom), ($urandom_range(0, 3) == 0), $urandom_range(0, 4) == 0,
            ($urandom_range(0, 15) != 0));
      check_all("R1 R2 R5 random");
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule